// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block derives a display pixel clock from one of two candidate source clocks. Each source is represented by a tick enable in the block's own clock domain. Each tick stands for one half-cycle of the source clock. A control bit chooses which tick stream advances the divider.

The divide ratio has an integer part and a fraction in sixteenths of a source cycle. A phase accumulator stretches some output periods by one source cycle, so the long-term average period equals the programmed ratio. The rising and falling positions of the output are programmed on their own, in half-cycle units. The duty cycle is therefore free and need not be 50%.

Three registers are reached through a simple write port: the divide ratio, the edge positions and the control bits. Changes to the divide ratio and to the edge positions are held in shadow registers. They move into the active set only when one output period ends and the next begins. The output is a registered level, optionally inverted.

Top module: `pclk_divider`

## Requirements
- R1: After reset the output is low, the divide value is 0x10 (integer 1, fraction 0), the rise position is 0 and the fall position is 1. The output therefore toggles on every selected tick.
- R2: Address 0 holds the divide value: integer part in bits 11:4 and fraction in bits 3:0. With fraction 0 and integer N, every output period lasts exactly 2N selected ticks.
- R3: An integer part of 0 is treated as 1.
- R4: A fraction F makes each period last either 2N or 2N+2 ticks. Any 16 consecutive periods last exactly 32N+2F ticks in total.
- R5: Address 1 holds the fall position in bits 24:16 and the rise position in bits 8:0, both in ticks from the start of the period. At the tick whose phase equals the rise position the output goes high. At the tick whose phase equals the fall position it goes low. When the two positions are equal, rise wins.
- R6: Programming rise 0 and fall N gives N high ticks and N low ticks per period.
- R7: A write to address 0 or 1 changes nothing in the current output period. The new setting takes effect from the next period.
- R8: Address 2, bit 0 selects the tick source: 0 selects bus_tick_i and 1 selects ext_tick_i. Ticks on the unselected source are ignored.
- R9: Address 2, bit 1 inverts the output. The change appears in the cycle after the write, without waiting for a tick.
- R10: The output level and the phase hold while no selected tick arrives.
- R11: An edge position at or beyond the period length never produces an edge.
- R12: Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_tick_i | input | 1 | Half-cycle enable of the internal bus clock |
| ext_tick_i | input | 1 | Half-cycle enable of the external display clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 divide, 1 edges, 2 control |
| wr_data_i | input | 32 | Register write data |
| pix_clk_o | output | 1 | Pixel clock level |

## Verification
The bench sweeps integer ratios against every fraction. It checks each period length and the 16-period total, which exposes an accumulator that drops or doubles a carry, or that inserts a half-cycle instead of a full source cycle. It writes new settings in the middle of a period; a design that applied them at once would shorten that period into a runt. Equal rise and fall positions, positions past the end of the period, and a zero integer part are each driven. Wrong priority, a spurious edge, or a zero-length period would show up as a stuck or missing output level. Source selection, idle stalls, immediate inversion and the unused address are checked at the output, alongside a cycle-by-cycle model.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
   typedef enum logic [1:0] {
      PCK_DIV  = 2'd0,
      PCK_EDGE = 2'd1,
      PCK_CTRL = 2'd2,
      PCK_NONE = 2'd3
   } pclk_addr_e;

   localparam int FALL_LSB = 16;
   localparam int CTRL_SRC = 0;
   localparam int CTRL_INV = 1;
endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
   import pclk_pkg::*;
#(
   parameter int INT_W     = 8,
   parameter int FRAC_W    = 4,
   parameter int POS_W     = 9,
   parameter bit INVERT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [31:0]       wr_data_i,
   output logic [INT_W-1:0]  int_o,
   output logic [FRAC_W-1:0] frac_o,
   output logic [POS_W-1:0]  rise_o,
   output logic [POS_W-1:0]  fall_o,
   output logic              src_o,
   output logic              inv_o
);
   localparam int INT_LSB = FRAC_W;

   logic [INT_W-1:0] new_int;
   logic             unused_data;

   assign new_int     = wr_data_i[INT_LSB +: INT_W];
   assign unused_data = ^wr_data_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_o  <= INT_W'(1);
         frac_o <= '0;
         rise_o <= '0;
         fall_o <= POS_W'(1);
         src_o  <= 1'b0;
      end else if (wr_en_i) begin
         case (pclk_addr_e'(wr_addr_i))
            PCK_DIV: begin
               int_o  <= (new_int == '0) ? INT_W'(1) : new_int;
               frac_o <= wr_data_i[FRAC_W-1:0];
            end
            PCK_EDGE: begin
               rise_o <= wr_data_i[POS_W-1:0];
               fall_o <= wr_data_i[FALL_LSB +: POS_W];
            end
            PCK_CTRL: src_o <= wr_data_i[CTRL_SRC];
            default: ;
         endcase
      end
   end

   generate
      if (INVERT_EN) begin : g_inv
         always_ff @(posedge clk) begin
            if (!rst_n)
               inv_o <= 1'b0;
            else if (wr_en_i && pclk_addr_e'(wr_addr_i) == PCK_CTRL)
               inv_o <= wr_data_i[CTRL_INV];
         end
      end else begin : g_no_inv
         assign inv_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pclk_period.sv
module pclk_period #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 4,
   parameter int PH_W   = INT_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [INT_W-1:0]  sh_int_i,
   input  logic [FRAC_W-1:0] sh_frac_i,
   output logic [PH_W-1:0]   phase_o,
   output logic [PH_W-1:0]   last_o,
   output logic              wrap_o,
   output logic [INT_W-1:0]  act_int_o,
   output logic              extra_o
);
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   acc_sum;

   assign last_o  = (PH_W'(act_int_o) << 1) + (PH_W'(extra_o) << 1) - PH_W'(1);
   assign wrap_o  = tick_i && (phase_o == last_o);
   assign acc_sum = {1'b0, acc_q} + {1'b0, sh_frac_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_o   <= '0;
         act_int_o <= INT_W'(1);
         extra_o   <= 1'b0;
         acc_q     <= '0;
      end else if (wrap_o) begin
         phase_o   <= '0;
         act_int_o <= sh_int_i;
         extra_o   <= acc_sum[FRAC_W];
         acc_q     <= acc_sum[FRAC_W-1:0];
      end else if (tick_i) begin
         phase_o   <= phase_o + PH_W'(1);
      end
   end
endmodule

// File: rtl/pclk_edge.sv
module pclk_edge #(
   parameter int POS_W = 9,
   parameter int PH_W  = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             wrap_i,
   input  logic [PH_W-1:0]  phase_i,
   input  logic [POS_W-1:0] sh_rise_i,
   input  logic [POS_W-1:0] sh_fall_i,
   output logic             lvl_o
);
   localparam int CW = (POS_W > PH_W) ? POS_W : PH_W;

   logic [POS_W-1:0] rise_q, fall_q;
   logic             hit_rise, hit_fall;

   assign hit_rise = (CW'(phase_i) == CW'(rise_q));
   assign hit_fall = (CW'(phase_i) == CW'(fall_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rise_q <= '0;
         fall_q <= POS_W'(1);
         lvl_o  <= 1'b0;
      end else if (tick_i) begin
         if (hit_rise)
            lvl_o <= 1'b1;
         else if (hit_fall)
            lvl_o <= 1'b0;
         if (wrap_i) begin
            rise_q <= sh_rise_i;
            fall_q <= sh_fall_i;
         end
      end
   end
endmodule

// File: rtl/pclk_divider.sv
module pclk_divider #(
   parameter int INT_W     = 8,
   parameter int FRAC_W    = 4,
   parameter int POS_W     = 9,
   parameter bit INVERT_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_tick_i,
   input  logic        ext_tick_i,
   input  logic        wr_en_i,
   input  logic [1:0]  wr_addr_i,
   input  logic [31:0] wr_data_i,
   output logic        pix_clk_o
);
   localparam int PH_W = INT_W + 2;

   initial begin
      assert (INT_W >= 1 && FRAC_W >= 1 && INT_W + FRAC_W <= 16)
         else $error("divide field widths out of range");
      assert (POS_W >= INT_W + 1 && POS_W <= 16)
         else $error("edge position width out of range");
   end

   logic [INT_W-1:0]  sh_int, act_int;
   logic [FRAC_W-1:0] sh_frac;
   logic [POS_W-1:0]  sh_rise, sh_fall;
   logic              src_sel, inv, tick, wrap, extra, lvl;
   logic [PH_W-1:0]   phase, period_last;

   pclk_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .POS_W(POS_W), .INVERT_EN(INVERT_EN)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .int_o(sh_int), .frac_o(sh_frac),
      .rise_o(sh_rise), .fall_o(sh_fall), .src_o(src_sel), .inv_o(inv)
   );

   assign tick = src_sel ? ext_tick_i : bus_tick_i;

   pclk_period #(.INT_W(INT_W), .FRAC_W(FRAC_W), .PH_W(PH_W)) u_period (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .sh_int_i(sh_int),
      .sh_frac_i(sh_frac), .phase_o(phase), .last_o(period_last),
      .wrap_o(wrap), .act_int_o(act_int), .extra_o(extra)
   );

   pclk_edge #(.POS_W(POS_W), .PH_W(PH_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .wrap_i(wrap),
      .phase_i(phase), .sh_rise_i(sh_rise), .sh_fall_i(sh_fall), .lvl_o(lvl)
   );

   assign pix_clk_o = lvl ^ inv;
endmodule

// File: rtl/pclk_divider_chk.sv
module pclk_divider_chk #(
   parameter int INT_W = 8,
   parameter int PH_W  = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             wrap,
   input logic [PH_W-1:0]  phase,
   input logic [PH_W-1:0]  period_last,
   input logic [INT_W-1:0] act_int,
   input logic             extra,
   input logic             lvl
);
   a_r2_phase_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= period_last);

   a_r2_wrap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> phase == '0);

   a_r3_int_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      act_int != '0);

   a_r7_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(act_int));

   a_r4_extra_held: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(extra));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(lvl) && $stable(phase)));
endmodule

bind pclk_divider pclk_divider_chk #(.INT_W(INT_W), .PH_W(PH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .phase(phase),
   .period_last(period_last), .act_int(act_int), .extra(extra), .lvl(lvl)
);

// File: tb/sim_pclk_divider.sv
module sim_pclk_divider;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bt = 1'b0, et = 1'b0, we = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] data = '0;
   logic        pix;

   int total = 0, bad = 0;
   int seg_err = 0, seg_act = 0, seg_exp = 0;
   bit done = 0;

   // reference model state
   int m_sint = 1, m_sfrac = 0, m_srise = 0, m_sfall = 1, m_sel = 0, m_inv = 0;
   int m_int = 1, m_ext = 0, m_acc = 0, m_rise = 0, m_fall = 1, m_ph = 0, m_lvl = 0;

   always #5 clk = ~clk;

   pclk_divider u0 (
      .clk(clk), .rst_n(rst_n), .bus_tick_i(bt), .ext_tick_i(et),
      .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(data), .pix_clk_o(pix)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_step();
      int t, last, s, i;
      t = m_sel ? int'(et) : int'(bt);
      if (t != 0) begin
         last = 2 * m_int + 2 * m_ext - 1;
         if (m_ph == m_rise) m_lvl = 1;
         else if (m_ph == m_fall) m_lvl = 0;
         if (m_ph == last) begin
            m_ph = 0; m_int = m_sint; s = m_acc + m_sfrac;
            m_ext = s / 16; m_acc = s % 16; m_rise = m_srise; m_fall = m_sfall;
         end else m_ph++;
      end
      if (we) begin
         case (addr)
            2'd0: begin i = int'(data[11:4]); m_sint = (i == 0) ? 1 : i; m_sfrac = int'(data[3:0]); end
            2'd1: begin m_srise = int'(data[8:0]); m_sfall = int'(data[24:16]); end
            2'd2: begin m_sel = int'(data[0]); m_inv = int'(data[1]); end
            default: ;
         endcase
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      #1;
      if (int'(pix) != (m_lvl ^ m_inv) && seg_err++ == 0) begin
         seg_act = int'(pix); seg_exp = m_lvl ^ m_inv;
      end
   endtask

   task automatic seg_check(input string req);
      total++;
      if (seg_err != 0) begin
         bad++;
         $display("FAIL %s model mismatch actual=%0d expected=%0d (%0d cycles)", req, seg_act, seg_exp, seg_err);
      end
      seg_err = 0;
   endtask

   task automatic wr(input int a, input int d);
      we = 1'b1; addr = 2'(a); data = 32'(d);
      cyc();
      we = 1'b0;
   endtask

   // wait for a rising edge of the output
   task automatic wait_rise();
      int p;
      p = int'(pix);
      for (int k = 0; k < 2000; k++) begin
         cyc();
         if (p == 0 && pix) break;
         p = int'(pix);
      end
   endtask

   // measure n periods starting at a rising edge
   task automatic meas(input int n, output int sum, output int mn, output int mx, output int hmis, input int hexp);
      int c, h;
      wait_rise();
      sum = 0; mn = 100000; mx = 0; hmis = 0;
      for (int j = 0; j < n; j++) begin
         c = 0; h = 0;
         for (int k = 0; k < 2000; k++) begin
            if (pix) h++;
            cyc(); c++;
            if (pix && h != c) break;
         end
         sum += c;
         if (c < mn) mn = c;
         if (c > mx) mx = c;
         if (h != hexp) hmis++;
      end
   endtask

   initial begin
      #1500000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int sum, mn, mx, hm, lows, chg, p, c;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset level", int'(pix), 0);
      rst_n = 1'b1;
      bt = 1'b1;
      cyc();
      chk("R1 first tick rises", int'(pix), 1);
      cyc();
      chk("R1 second tick falls", int'(pix), 0);
      meas(4, sum, mn, mx, hm, 1);
      chk("R1 default period", mx, 2);
      seg_check("R1");

      // R2 R4 R6 sweep over integer and fraction
      for (int n = 1; n <= 6; n++) begin
         for (int f = 0; f < 16; f++) begin
            wr(0, (n << 4) | f);
            wr(1, n << 16);
            meas(2, sum, mn, mx, hm, n);
            meas(16, sum, mn, mx, hm, n);
            if (f == 0) chk("R2 integer period", mx, 2 * n);
            chk("R4 sixteen-period total", sum, 32 * n + 2 * f);
            chk("R4 period range", int'(mn >= 2 * n && mx <= 2 * n + 2 && (f == 0 || mx == 2 * n + 2)), 1);
            chk("R6 high time", hm, 0);
         end
      end
      seg_check("R5 sweep");

      // R3 zero integer
      wr(0, 0);
      wr(1, 1 << 16);
      meas(2, sum, mn, mx, hm, 1);
      meas(4, sum, mn, mx, hm, 1);
      chk("R3 zero integer as one", mx, 2);
      seg_check("R3");

      // R5 equal positions: rise wins
      wr(0, 4 << 4);
      wr(1, (3 << 16) | 3);
      repeat (20) cyc();
      lows = 0;
      repeat (24) begin cyc(); if (!pix) lows++; end
      chk("R5 rise wins on tie", lows, 0);
      seg_check("R5");

      // R11 fall beyond period
      wr(0, 2 << 4);
      wr(1, (9 << 16) | 1);
      repeat (12) cyc();
      lows = 0;
      repeat (24) begin cyc(); if (!pix) lows++; end
      chk("R11 no edge past period", lows, 0);
      seg_check("R11");

      // R7 change mid-period
      wr(1, 2 << 16);
      meas(2, sum, mn, mx, hm, 2);
      wait_rise();
      wr(0, 6 << 4);
      wr(1, 6 << 16);
      c = 2;
      for (int k = 0; k < 100; k++) begin
         p = int'(pix); cyc(); c++;
         if (p == 0 && pix) break;
      end
      chk("R7 current period untouched", c, 4);
      meas(1, sum, mn, mx, hm, 6);
      chk("R7 next period uses new ratio", sum, 12);
      seg_check("R7");

      // R8 R10 source select and idle
      bt = 1'b0; et = 1'b1;
      p = int'(pix); chg = 0;
      repeat (30) begin cyc(); if (int'(pix) != p) chg++; p = int'(pix); end
      chk("R10 unselected ticks ignored", chg, 0);
      wr(2, 1);
      meas(2, sum, mn, mx, hm, 6);
      chk("R8 external source period", mx, 12);
      seg_check("R8");

      // R9 inversion while idle
      et = 1'b0;
      cyc();
      p = int'(pix);
      wr(2, 3);
      chk("R9 inversion immediate", int'(pix), 1 - p);
      wr(2, 1);
      chk("R9 inversion removed", int'(pix), p);
      seg_check("R9");

      // R12 unused address
      et = 1'b1;
      wr(3, 32'h0001_0010);
      meas(2, sum, mn, mx, hm, 6);
      chk("R12 address 3 ignored", mx, 12);
      seg_check("R12");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule